// File: doc/BRIEF.md
# GPIO Port Register Bank

This block holds the software-visible state of one general-purpose I/O port: a data-out register, an output-enable register (1 = pin driven) and a synchronised copy of the pin levels. Software does not write these registers whole. It issues one command per cycle: set data bits, clear data bits, turn bits into inputs, turn bits into outputs, or read one of the three values. Every change is a read-modify-write that finishes in the cycle the command is accepted. Because of this, two commands can never interleave.

Two build-time masks guard the port. One lists the data bits that software may set or clear. The other lists the bits whose direction software may change. A bit outside a mask keeps its reset value for the life of the port. Each command returns a registered response one cycle later. Turning bits into inputs returns the set of input pins: the new output-enable value inverted across the port width.

Top module: `gpio_port_bank`

## Requirements
- R1: While reset is asserted and after it is released, `dout_o` equals `DOUT_RST`, `oe_o` equals `OE_RST` and `rsp_valid_o` is 0 until the first command.
- R2: Command code 1 (set bits) makes `dout_o` = `dout_o | (cmd_arg & CHG_DATA)`. The response is the new data-out value.
- R3: Command code 2 (clear bits) makes `dout_o` = `dout_o & ~(cmd_arg & CHG_DATA)`. The response is the new data-out value.
- R4: Command code 3 (make inputs) makes `oe_o` = `oe_o & ~(cmd_arg & CHG_DIR)`. The response is the new `oe_o` XOR all ones over `WIDTH` bits.
- R5: Command code 4 (make outputs) makes `oe_o` = `oe_o | (cmd_arg & CHG_DIR)`. The response is the new `oe_o`.
- R6: No command changes a data-out bit that is 0 in `CHG_DATA`, or an output-enable bit that is 0 in `CHG_DIR`.
- R7: Read commands do not change state. Code 0 returns `din_o`, code 5 returns `dout_o` and code 6 returns `oe_o`, each as it was when the command was accepted.
- R8: A command accepted at a clock edge updates `dout_o`/`oe_o` at that edge. It sets `rsp_valid_o` with `rsp_data_o` for the following cycle. A command in the next cycle sees the updated state.
- R9: `din_o` equals `pin_in` as it was two clock edges earlier, whatever the value of `oe_o`.
- R10: Command code 7 is reserved. It changes nothing and returns a response of 0.
- R11: In a cycle with `cmd_valid` low, `dout_o` and `oe_o` hold their values and `rsp_valid_o` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (0..7, see requirements) |
| cmd_arg | input | WIDTH | Bit argument of the command |
| pin_in | input | WIDTH | Asynchronous pin levels |
| dout_o | output | WIDTH | Data-out register |
| oe_o | output | WIDTH | Output-enable register, 1 = output |
| din_o | output | WIDTH | Synchronised pin levels |
| rsp_valid_o | output | 1 | Response valid, one cycle after a command |
| rsp_data_o | output | WIDTH | Response value |

## Verification
The assertions take two things for granted. First, `cmd_op` and `cmd_arg` are only meaningful while `cmd_valid` is high. Second, `pin_in` may change at any time, because only the synchroniser output is checked. The bench drives every command and pin change on the falling clock edge, so each command is stable across the rising edge that accepts it. It also holds `cmd_valid` low whenever it tests that the state stays put. The stimulus includes arguments with every bit set, so the protection masks are exercised against arguments that would otherwise touch the guarded bits.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
    typedef enum logic [2:0] {
        GPB_RD_IN   = 3'd0,
        GPB_SET     = 3'd1,
        GPB_CLR     = 3'd2,
        GPB_MK_IN   = 3'd3,
        GPB_MK_OUT  = 3'd4,
        GPB_RD_OUT  = 3'd5,
        GPB_RD_DIR  = 3'd6,
        GPB_RSVD    = 3'd7
    } gpb_op_e;
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int WIDTH  = 18,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int k = 1; k < STAGES; k++) begin
            stg_d[k] = stg_q[k-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < STAGES; k++) begin
            if (!rst_n) stg_q[k] <= '0;
            else        stg_q[k] <= stg_d[k];
        end
    end

    assign sync_o = stg_q[LAST];

    // R9: the last stage only ever takes the previous stage's value
    p_sync_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sync_o == $past(stg_q[(LAST > 0) ? LAST-1 : 0]) || LAST == 0));
endmodule

// File: rtl/gpb_next.sv
module gpb_next
    import gpb_pkg::*;
#(
    parameter int               WIDTH    = 18,
    parameter logic [WIDTH-1:0] CHG_DATA = '1,
    parameter logic [WIDTH-1:0] CHG_DIR  = '1
) (
    input  gpb_op_e          op,
    input  logic [WIDTH-1:0] arg,
    input  logic [WIDTH-1:0] dout_cur,
    input  logic [WIDTH-1:0] oe_cur,
    input  logic [WIDTH-1:0] din_cur,
    output logic [WIDTH-1:0] dout_nxt,
    output logic [WIDTH-1:0] oe_nxt,
    output logic [WIDTH-1:0] rsp
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    logic [WIDTH-1:0] data_sel;
    logic [WIDTH-1:0] dir_sel;

    always_comb begin
        data_sel = arg & CHG_DATA;
        dir_sel  = arg & CHG_DIR;
        dout_nxt = dout_cur;
        oe_nxt   = oe_cur;
        rsp      = '0;
        case (op)
            GPB_SET: begin
                dout_nxt = dout_cur | data_sel;
                rsp      = dout_nxt;
            end
            GPB_CLR: begin
                dout_nxt = dout_cur & ~data_sel;
                rsp      = dout_nxt;
            end
            GPB_MK_IN: begin
                oe_nxt = oe_cur & ~dir_sel;
                rsp    = oe_nxt ^ ALL_ONES;
            end
            GPB_MK_OUT: begin
                oe_nxt = oe_cur | dir_sel;
                rsp    = oe_nxt;
            end
            GPB_RD_IN:  rsp = din_cur;
            GPB_RD_OUT: rsp = dout_cur;
            GPB_RD_DIR: rsp = oe_cur;
            default:    rsp = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
    import gpb_pkg::*;
#(
    parameter int               WIDTH       = 18,
    parameter logic [WIDTH-1:0] CHG_DATA    = 18'h3C3FF,
    parameter logic [WIDTH-1:0] CHG_DIR     = 18'h0FFF0,
    parameter logic [WIDTH-1:0] DOUT_RST    = 18'h00003,
    parameter logic [WIDTH-1:0] OE_RST      = 18'h00F00,
    parameter int               SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [WIDTH-1:0] cmd_arg,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] dout_o,
    output logic [WIDTH-1:0] oe_o,
    output logic [WIDTH-1:0] din_o,
    output logic             rsp_valid_o,
    output logic [WIDTH-1:0] rsp_data_o
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    typedef struct packed {
        logic [WIDTH-1:0] dout;
        logic [WIDTH-1:0] oe;
        logic [WIDTH-1:0] rsp;
        logic             vld;
    } bank_t;

    bank_t            st_d, st_q;
    logic [WIDTH-1:0] din_sync;
    logic [WIDTH-1:0] dout_n, oe_n, rsp_n;
    gpb_op_e          op;

    assign op = gpb_op_e'(cmd_op);

    gpb_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (din_sync)
    );

    gpb_next #(.WIDTH(WIDTH), .CHG_DATA(CHG_DATA), .CHG_DIR(CHG_DIR)) u_next (
        .op       (op),
        .arg      (cmd_arg),
        .dout_cur (st_q.dout),
        .oe_cur   (st_q.oe),
        .din_cur  (din_sync),
        .dout_nxt (dout_n),
        .oe_nxt   (oe_n),
        .rsp      (rsp_n)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (cmd_valid) begin
            st_d.dout = dout_n;
            st_d.oe   = oe_n;
            st_d.rsp  = rsp_n;
            st_d.vld  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.dout <= DOUT_RST;
            st_q.oe   <= OE_RST;
            st_q.rsp  <= '0;
            st_q.vld  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_o      = st_q.dout;
    assign oe_o        = st_q.oe;
    assign din_o       = din_sync;
    assign rsp_valid_o = st_q.vld;
    assign rsp_data_o  = st_q.rsp;

    // R6: protected data bits never move
    p_data_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((dout_o ^ $past(dout_o)) & ~CHG_DATA) == '0));
    // R6: protected direction bits never move
    p_dir_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((oe_o ^ $past(oe_o)) & ~CHG_DIR) == '0));
    // R2: a set never clears a data bit
    p_set_monotone_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == GPB_SET) |=> ((~dout_o & $past(dout_o)) == '0));
    // R3: a clear never raises a data bit
    p_clr_monotone_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == GPB_CLR) |=> ((dout_o & ~$past(dout_o)) == '0));
    // R4: make-inputs answers with the inverted direction
    p_mkin_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == GPB_MK_IN) |=> (rsp_data_o == (oe_o ^ ALL_ONES)));
    // R5: make-outputs answers with the direction itself
    p_mkout_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == GPB_MK_OUT) |=> (rsp_data_o == oe_o));
    // R8: every accepted command yields a response next cycle
    p_rsp_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid_o);
    // R11: idle cycles hold state and give no response
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> ($stable(dout_o) && $stable(oe_o) && !rsp_valid_o));
    // R10: the reserved code leaves state alone and answers zero
    p_rsvd_inert_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == GPB_RSVD) |=> ($stable(dout_o) && $stable(oe_o) && rsp_data_o == '0));
endmodule

// File: tb/test_gpio_port_bank.sv
module test_gpio_port_bank;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         cmd_valid;
    logic [2:0]   cmd_op;
    logic [W-1:0] cmd_arg;
    logic [W-1:0] pin_in;
    logic [W-1:0] dout_o, oe_o, din_o, rsp_data_o;
    logic         rsp_valid_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    gpio_port_bank i_gpio_port_bank (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .pin_in(pin_in), .dout_o(dout_o), .oe_o(oe_o),
        .din_o(din_o), .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o)
    );

    typedef struct packed {
        logic [2:0]   op;
        logic [W-1:0] arg;
        logic [W-1:0] rsp;
        logic [W-1:0] dout;
        logic [W-1:0] oe;
    } vec_t;

    // masks: data 0x3C3FF, direction 0x0FFF0; reset dout 0x00003, oe 0x00F00
    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{3'd1, 18'h3FFFF, 18'h3C3FF, 18'h3C3FF, 18'h00F00}, // R2
        '{3'd2, 18'h00F0F, 18'h3C0F0, 18'h3C0F0, 18'h00F00}, // R3
        '{3'd4, 18'h3000F, 18'h00F00, 18'h3C0F0, 18'h00F00}, // R5 R6 all guarded
        '{3'd4, 18'h000FF, 18'h00FF0, 18'h3C0F0, 18'h00FF0}, // R5
        '{3'd3, 18'h00300, 18'h3F30F, 18'h3C0F0, 18'h00CF0}, // R4
        '{3'd3, 18'h30003, 18'h3F30F, 18'h3C0F0, 18'h00CF0}, // R4 R6 all guarded
        '{3'd2, 18'h3FFFF, 18'h00000, 18'h00000, 18'h00CF0}, // R3
        '{3'd1, 18'h03C00, 18'h00000, 18'h00000, 18'h00CF0}, // R2 R6 all guarded
        '{3'd1, 18'h20001, 18'h20001, 18'h20001, 18'h00CF0}, // R2
        '{3'd5, 18'h3FFFF, 18'h20001, 18'h20001, 18'h00CF0}, // R7
        '{3'd6, 18'h00000, 18'h00CF0, 18'h20001, 18'h00CF0}, // R7
        '{3'd7, 18'h3FFFF, 18'h00000, 18'h20001, 18'h00CF0}, // R10
        '{3'd4, 18'h3FFFF, 18'h0FFF0, 18'h20001, 18'h0FFF0}, // R5
        '{3'd3, 18'h3FFFF, 18'h3FFFF, 18'h20001, 18'h00000}  // R4 full-width inversion
    };

    function automatic string op_req(input logic [2:0] op);
        case (op)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd7: return "R10";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [W-1:0] arg);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_arg   = arg;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_arg = '0; pin_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 dout", dout_o, 18'h00003);
        chk("R1 oe", oe_o, 18'h00F00);
        chk("R1 rsp_valid", {17'd0, rsp_valid_o}, 18'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", dout_o, 18'h00003);

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i].op, VEC[i].arg);
            chk({op_req(VEC[i].op), " rsp"}, rsp_data_o, VEC[i].rsp);
            chk("R8 rsp_valid", {17'd0, rsp_valid_o}, 18'd1);
            chk("R6 dout", dout_o, VEC[i].dout);
            chk("R6 oe", oe_o, VEC[i].oe);
        end

        // R11: idle cycle
        cmd_valid = 1'b0;
        cmd_arg   = 18'h3FFFF;
        cmd_op    = 3'd1;
        @(negedge clk);
        chk("R11 rsp_valid", {17'd0, rsp_valid_o}, 18'd0);
        chk("R11 dout", dout_o, 18'h20001);
        chk("R11 oe", oe_o, 18'h00000);

        // R9: two-edge pin latency with all pins inputs
        pin_in = 18'h2A5A5;
        @(negedge clk);
        chk("R9 one edge", din_o, 18'h00000);
        @(negedge clk);
        chk("R9 two edges", din_o, 18'h2A5A5);
        issue(3'd0, 18'h00000);
        chk("R7 read input", rsp_data_o, 18'h2A5A5);

        // R9: direction does not affect the input path
        pin_in = 18'h15A5A;
        issue(3'd4, 18'h3FFFF);
        chk("R5 rsp", rsp_data_o, 18'h0FFF0);
        chk("R9 one edge with outputs", din_o, 18'h2A5A5);
        cmd_valid = 1'b0;
        @(negedge clk);
        chk("R9 two edges with outputs", din_o, 18'h15A5A);

        // R8: back-to-back set then clear
        issue(3'd1, 18'h00010);
        chk("R8 first rsp", rsp_data_o, 18'h20011);
        issue(3'd2, 18'h00001);
        chk("R8 second rsp", rsp_data_o, 18'h20010);
        chk("R8 second dout", dout_o, 18'h20010);
        cmd_valid = 1'b0;

        // R1: reset mid-run restores defaults
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 mid-run dout", dout_o, 18'h00003);
        chk("R1 mid-run oe", oe_o, 18'h00F00);
        chk("R1 mid-run rsp_valid", {17'd0, rsp_valid_o}, 18'd0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule